// File: doc/BRIEF.md
# DRAM Command Sequence Timing Scheduler

This block turns one memory request, expressed as a short ordered list of DRAM commands (row open, row close, read, write) aimed at a single bank, into a set of start and end cycles for those commands. The first command is placed at the requested cycle or later, each following command is placed exactly when its predecessor finishes, and no command of the request may begin before the target bank's previously scheduled work has ended. Time is measured by a free-running cycle counter inside the block, so every start lands on a clock edge.

The block also owns the refresh plan. A refresh is due every `REF_CYC` cycles (by default 15.6 us of a 5 ns clock, 3120 cycles) and lasts `T_RFC` cycles (21). A request whose commands would overlap the coming refresh window is refused as a whole and produces no commands. When a refresh goes out it becomes the most recent activity of every bank at once, so later requests on any bank wait for it to finish.

A request is offered by pulsing `req_valid` for one cycle; one cycle later the block answers on `resp_valid` with the accept or reject decision and, when accepted, the scheduled commands on parallel lanes.

Top module: `dram_seq_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `resp_valid`, `ref_valid` and every `cmd_valid` bit are 0 and `now_cycle` is 0; afterwards `now_cycle` rises by one per clock.
- R2: The first command of an accepted request starts at the largest of `req_start`, the current `now_cycle`, and the end of the target bank's last scheduled command.
- R3: Every later command of a request starts at the end cycle of the command before it in the same request.
- R4: Command codes on `req_ops` (2 bits per lane, lane i at bits 2i+1:2i) are 0 = row open, 1 = row close, 2 = read, 3 = write; their lengths are `T_ACT`, `T_PRE`, `T_RL` + burst and `T_WL` + burst cycles, and each lane reports end = start + length.
- R5: A request on a bank whose last scheduled command ends later than the requested start is delayed until that end.
- R6: Work scheduled on one bank does not delay a request on another bank.
- R7: A refresh fires at every multiple of `REF_CYC` counted from reset; `ref_valid` pulses one cycle later with `ref_start` equal to that multiple and `ref_end` equal to it plus `T_RFC`.
- R8: If any command [start, end) of a request overlaps the planned refresh window [plan, plan + `T_RFC`), the response has `resp_accept` = 0, all `cmd_valid` bits 0, and the bank's recorded end is left unchanged.
- R9: A refresh becomes the last activity of every bank: each bank's recorded end becomes at least the refresh end, while a later recorded end is kept.
- R10: Each `req_valid` pulse is answered by `resp_valid` exactly one cycle later; on acceptance, `cmd_valid` bit i is 1 exactly for lanes i below `req_cnt`, and the lane carries the bank and command code of the request.
- R11: The window test is half-open: a command ending exactly at the planned refresh cycle, or starting exactly at its end, is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_bank | input | BANK_W | Target bank |
| req_cnt | input | CNT_W | Number of commands in the request (0 to MAX_SEQ) |
| req_ops | input | 2*MAX_SEQ | Command codes, lane i at bits 2i+1:2i |
| req_burst | input | BL_W | Burst length for reads and writes |
| req_start | input | CYC_W | Earliest cycle for the first command |
| resp_valid | output | 1 | Decision for the request of the previous cycle |
| resp_accept | output | 1 | 1 = scheduled, 0 = refused |
| cmd_valid | output | MAX_SEQ | Lane holds a scheduled command |
| cmd_op | output | 2*MAX_SEQ | Command code per lane |
| cmd_bank | output | BANK_W | Bank of the scheduled commands |
| cmd_start | output | CYC_W*MAX_SEQ | Start cycle per lane |
| cmd_end | output | CYC_W*MAX_SEQ | End cycle per lane |
| ref_valid | output | 1 | Refresh issued |
| ref_start | output | CYC_W | Refresh start cycle |
| ref_end | output | CYC_W | Refresh end cycle |
| now_cycle | output | CYC_W | Free-running cycle count |

## Verification
A decision is due one clock after its strobe: inputs change just after a falling edge, the rising edge that follows makes the decision with the `now_cycle` seen at that moment, and the result is compared at the next falling edge. The bench keeps its own cycle count and its own per-bank end times and refresh plan, so every expected start and end is computed before the strobe and queued; a refresh pulse is due one cycle after the planned cycle and is checked against the bench's plan. The boundary requests near the first refresh are placed one cycle either side of the window edges.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

    typedef enum logic [1:0] {
        OP_OPEN  = 2'd0,
        OP_CLOSE = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    // Convert a time in picoseconds into whole clock cycles.
    function automatic int cycles_of(input int t_ps, input int clk_ps);
        return t_ps / clk_ps;
    endfunction

endpackage

// File: rtl/dsched_seq_timer.sv
module dsched_seq_timer
    import dsched_pkg::*;
#(
    parameter int MAX_SEQ = 3,
    parameter int CYC_W   = 32,
    parameter int BL_W    = 4,
    parameter int CNT_W   = 2,
    parameter int T_ACT   = 4,
    parameter int T_PRE   = 4,
    parameter int T_RL    = 5,
    parameter int T_WL    = 4,
    parameter int T_RFC   = 21
) (
    input  logic [CYC_W-1:0]         now,
    input  logic [CYC_W-1:0]         req_start,
    input  logic [CYC_W-1:0]         bank_end,
    input  logic [CYC_W-1:0]         plan,
    input  logic [CNT_W-1:0]         cnt,
    input  logic [2*MAX_SEQ-1:0]     ops,
    input  logic [BL_W-1:0]          burst,
    output logic [CYC_W*MAX_SEQ-1:0] starts,
    output logic [CYC_W*MAX_SEQ-1:0] ends,
    output logic [CYC_W-1:0]         seq_end,
    output logic                     fits
);

    logic [CYC_W-1:0] cursor;
    logic [CYC_W-1:0] win_hi;
    logic [CYC_W-1:0] len;
    logic [CYC_W-1:0] lane_end;

    function automatic logic [CYC_W-1:0] op_len(input op_e op, input logic [BL_W-1:0] bl);
        case (op)
            OP_OPEN:  return CYC_W'(T_ACT);
            OP_CLOSE: return CYC_W'(T_PRE);
            OP_READ:  return CYC_W'(T_RL) + CYC_W'(bl);
            default:  return CYC_W'(T_WL) + CYC_W'(bl);
        endcase
    endfunction

    assign win_hi = plan + CYC_W'(T_RFC);

    always_comb begin
        cursor = (req_start > now) ? req_start : now;
        if (bank_end > cursor) cursor = bank_end;
        fits     = 1'b1;
        len      = '0;
        lane_end = '0;
        for (int i = 0; i < MAX_SEQ; i++) begin
            len      = op_len(op_e'(ops[2*i +: 2]), burst);
            lane_end = cursor + len;
            starts[i*CYC_W +: CYC_W] = cursor;
            ends[i*CYC_W +: CYC_W]   = lane_end;
            if (i < int'(cnt)) begin
                if ((cursor < win_hi) && (lane_end > plan)) fits = 1'b0;
                cursor = lane_end;
            end
        end
        seq_end = cursor;
    end

endmodule

// File: rtl/dsched_bank_table.sv
module dsched_bank_table #(
    parameter int BANKS  = 8,
    parameter int BANK_W = 3,
    parameter int CYC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [CYC_W-1:0]  rd_end,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [CYC_W-1:0]  wr_end,
    input  logic              ref_fire,
    input  logic [CYC_W-1:0]  ref_end
);

    logic [BANKS-1:0][CYC_W-1:0] bank_ends;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [CYC_W-1:0] end_q;
        logic             hit;

        assign hit = wr_en && (wr_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                end_q <= '0;
            end else if (hit) begin
                end_q <= wr_end;
            end else if (ref_fire && (ref_end > end_q)) begin
                end_q <= ref_end;
            end
        end

        assign bank_ends[b] = end_q;

        AST_REFRESH_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
            (ref_fire && !hit) |=> (end_q >= $past(ref_end)));  // R9
    end

    assign rd_end = bank_ends[rd_bank];

endmodule

// File: rtl/dsched_refresh_plan.sv
module dsched_refresh_plan #(
    parameter int CYC_W   = 32,
    parameter int REF_CYC = 3120,
    parameter int T_RFC   = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CYC_W-1:0] now,
    output logic [CYC_W-1:0] plan,
    output logic             fire,
    output logic [CYC_W-1:0] fire_end,
    output logic             ref_valid,
    output logic [CYC_W-1:0] ref_start,
    output logic [CYC_W-1:0] ref_end
);

    logic [CYC_W-1:0] plan_q;

    assign plan     = plan_q;
    assign fire     = (now == plan_q);
    assign fire_end = plan_q + CYC_W'(T_RFC);

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q    <= CYC_W'(REF_CYC);
            ref_valid <= 1'b0;
            ref_start <= '0;
            ref_end   <= '0;
        end else begin
            ref_valid <= fire;
            if (fire) begin
                plan_q    <= plan_q + CYC_W'(REF_CYC);
                ref_start <= plan_q;
                ref_end   <= fire_end;
            end
        end
    end

    AST_PLAN_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        fire |=> (plan_q == $past(plan_q) + CYC_W'(REF_CYC)));  // R7

    AST_REF_PULSE_AT_PLAN: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> (ref_start == now - CYC_W'(1)));  // R7

endmodule

// File: rtl/dram_seq_sched.sv
module dram_seq_sched
    import dsched_pkg::*;
#(
    parameter int BANKS   = 8,
    parameter int MAX_SEQ = 3,
    parameter int CYC_W   = 32,
    parameter int BL_W    = 4,
    parameter int T_ACT   = 4,
    parameter int T_PRE   = 4,
    parameter int T_RL    = 5,
    parameter int T_WL    = 4,
    parameter int T_RFC   = 21,
    parameter int CLK_PS  = 5000,
    parameter int REF_PS  = 15600000,
    parameter int REF_CYC = cycles_of(REF_PS, CLK_PS),
    localparam int BANK_W = $clog2(BANKS),
    localparam int CNT_W  = $clog2(MAX_SEQ + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [BANK_W-1:0]        req_bank,
    input  logic [CNT_W-1:0]         req_cnt,
    input  logic [2*MAX_SEQ-1:0]     req_ops,
    input  logic [BL_W-1:0]          req_burst,
    input  logic [CYC_W-1:0]         req_start,
    output logic                     resp_valid,
    output logic                     resp_accept,
    output logic [MAX_SEQ-1:0]       cmd_valid,
    output logic [2*MAX_SEQ-1:0]     cmd_op,
    output logic [BANK_W-1:0]        cmd_bank,
    output logic [CYC_W*MAX_SEQ-1:0] cmd_start,
    output logic [CYC_W*MAX_SEQ-1:0] cmd_end,
    output logic                     ref_valid,
    output logic [CYC_W-1:0]         ref_start,
    output logic [CYC_W-1:0]         ref_end,
    output logic [CYC_W-1:0]         now_cycle
);

    logic [CYC_W-1:0]         cyc_q;
    logic [CYC_W-1:0]         plan;
    logic                     ref_fire;
    logic [CYC_W-1:0]         ref_fire_end;
    logic [CYC_W-1:0]         bank_end;
    logic [CYC_W*MAX_SEQ-1:0] lane_starts;
    logic [CYC_W*MAX_SEQ-1:0] lane_ends;
    logic [CYC_W-1:0]         seq_end;
    logic                     fits;
    logic [MAX_SEQ-1:0]       live_mask;
    logic                     commit;

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= '0;
        else     cyc_q <= cyc_q + CYC_W'(1);
    end
    assign now_cycle = cyc_q;

    always_comb begin
        for (int i = 0; i < MAX_SEQ; i++) live_mask[i] = (i < int'(req_cnt));
    end

    assign commit = req_valid && fits && (req_cnt != '0);

    dsched_refresh_plan #(
        .CYC_W(CYC_W), .REF_CYC(REF_CYC), .T_RFC(T_RFC)
    ) u_plan (
        .clk(clk), .rst(rst), .now(cyc_q), .plan(plan), .fire(ref_fire),
        .fire_end(ref_fire_end), .ref_valid(ref_valid), .ref_start(ref_start),
        .ref_end(ref_end)
    );

    dsched_bank_table #(
        .BANKS(BANKS), .BANK_W(BANK_W), .CYC_W(CYC_W)
    ) u_banks (
        .clk(clk), .rst(rst), .rd_bank(req_bank), .rd_end(bank_end),
        .wr_en(commit), .wr_bank(req_bank), .wr_end(seq_end),
        .ref_fire(ref_fire), .ref_end(ref_fire_end)
    );

    dsched_seq_timer #(
        .MAX_SEQ(MAX_SEQ), .CYC_W(CYC_W), .BL_W(BL_W), .CNT_W(CNT_W),
        .T_ACT(T_ACT), .T_PRE(T_PRE), .T_RL(T_RL), .T_WL(T_WL), .T_RFC(T_RFC)
    ) u_timer (
        .now(cyc_q), .req_start(req_start), .bank_end(bank_end), .plan(plan),
        .cnt(req_cnt), .ops(req_ops), .burst(req_burst), .starts(lane_starts),
        .ends(lane_ends), .seq_end(seq_end), .fits(fits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
            cmd_valid   <= '0;
            cmd_op      <= '0;
            cmd_bank    <= '0;
            cmd_start   <= '0;
            cmd_end     <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                resp_accept <= fits;
                cmd_valid   <= fits ? live_mask : '0;
                cmd_op      <= req_ops;
                cmd_bank    <= req_bank;
                cmd_start   <= lane_starts;
                cmd_end     <= lane_ends;
            end else begin
                cmd_valid <= '0;
            end
        end
    end

    AST_ANSWER_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);  // R10

    AST_START_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && cmd_valid[0]) |->
            (cmd_start[CYC_W-1:0] >= $past(cyc_q)) && (cmd_start[CYC_W-1:0] >= $past(req_start)));  // R2

    AST_CLEAR_OF_REFRESH: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && cmd_valid[0]) |->
            ((cmd_end[CYC_W-1:0] <= $past(plan)) ||
             (cmd_start[CYC_W-1:0] >= $past(plan) + CYC_W'(T_RFC))));  // R8

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_accept) |-> (cmd_valid == '0));  // R8

    if (MAX_SEQ > 1) begin : g_chain_chk
        AST_CHAINED: assert property (@(posedge clk) disable iff (rst)
            cmd_valid[1] |-> (cmd_start[2*CYC_W-1:CYC_W] == cmd_end[CYC_W-1:0]));  // R3
    end

endmodule

// File: tb/dram_seq_sched_tb.sv
`timescale 1ns/1ps
module dram_seq_sched_tb;

    localparam int BANKS = 8, MAX_SEQ = 3, CYC_W = 32, BL_W = 4;
    localparam int BANK_W = 3, CNT_W = 2;
    localparam int T_ACT = 4, T_PRE = 4, T_RL = 5, T_WL = 4, T_RFC = 21;
    localparam int REF_CYC = 3120;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     req_valid = 1'b0;
    logic [BANK_W-1:0]        req_bank = '0;
    logic [CNT_W-1:0]         req_cnt = '0;
    logic [2*MAX_SEQ-1:0]     req_ops = '0;
    logic [BL_W-1:0]          req_burst = '0;
    logic [CYC_W-1:0]         req_start = '0;
    logic                     resp_valid, resp_accept;
    logic [MAX_SEQ-1:0]       cmd_valid;
    logic [2*MAX_SEQ-1:0]     cmd_op;
    logic [BANK_W-1:0]        cmd_bank;
    logic [CYC_W*MAX_SEQ-1:0] cmd_start, cmd_end;
    logic                     ref_valid;
    logic [CYC_W-1:0]         ref_start, ref_end, now_cycle;

    dram_seq_sched u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_cnt(req_cnt), .req_ops(req_ops), .req_burst(req_burst),
        .req_start(req_start), .resp_valid(resp_valid), .resp_accept(resp_accept),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .ref_valid(ref_valid),
        .ref_start(ref_start), .ref_end(ref_end), .now_cycle(now_cycle)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit     acc;
        int     cnt;
        int     bank;
        int     ops[MAX_SEQ];
        longint st[MAX_SEQ];
        longint en[MAX_SEQ];
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     errors = 0;
    int     checks = 0;
    longint tb_cyc = 0;
    longint bk_end[BANKS];
    longint plan = REF_CYC;
    int     ref_seen = 0;

    always @(posedge clk) begin
        if (rst) tb_cyc <= 0;
        else     tb_cyc <= tb_cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint got, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    function automatic longint op_len(input int op, input int bl);
        case (op)
            0: return T_ACT;
            1: return T_PRE;
            2: return T_RL + bl;
            default: return T_WL + bl;
        endcase
    endfunction

    // Driver: computes the expected schedule, pushes it, strobes the request.
    task automatic issue(input int bank, input int cnt, input int o0, input int o1,
                         input int o2, input int bl, input longint start, input string tag);
        exp_t   e;
        longint t;
        @(negedge clk); #1;
        e.ops[0] = o0; e.ops[1] = o1; e.ops[2] = o2;
        e.cnt = cnt; e.bank = bank; e.tag = tag; e.acc = 1'b1;
        t = (start > tb_cyc) ? start : tb_cyc;
        if (bk_end[bank] > t) t = bk_end[bank];
        for (int i = 0; i < MAX_SEQ; i++) begin
            e.st[i] = t;
            e.en[i] = t + op_len(e.ops[i], bl);
            if (i < cnt) begin
                if (e.st[i] < plan + T_RFC && e.en[i] > plan) e.acc = 1'b0;
                t = e.en[i];
            end
        end
        if (e.acc && cnt > 0) bk_end[bank] = t;
        sb.push_back(e);
        req_bank  = BANK_W'(bank);
        req_cnt   = CNT_W'(cnt);
        req_ops   = {2'(o2), 2'(o1), 2'(o0)};
        req_burst = BL_W'(bl);
        req_start = CYC_W'(start);
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        chk(sb.size() == 0, "R10", "pending responses after one cycle", sb.size(), 0);
        while (sb.size() != 0) void'(sb.pop_front());
    endtask

    // Monitor: compares responses and refresh pulses at the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (resp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10", "unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    logic [MAX_SEQ-1:0] m;
                    e = sb.pop_front();
                    chk(resp_accept == e.acc, e.tag, "accept", resp_accept, e.acc);
                    for (int i = 0; i < MAX_SEQ; i++) m[i] = e.acc && (i < e.cnt);
                    chk(cmd_valid == m, e.tag, "lane valid mask", cmd_valid, m);
                    if (e.acc) begin
                        chk(cmd_bank == BANK_W'(e.bank), "R10", "bank", cmd_bank, e.bank);
                        for (int i = 0; i < MAX_SEQ; i++) begin
                            if (i < e.cnt) begin
                                chk(int'(cmd_op[2*i +: 2]) == e.ops[i], "R10", "op code",
                                    cmd_op[2*i +: 2], e.ops[i]);
                                chk(longint'(cmd_start[i*CYC_W +: CYC_W]) == e.st[i], e.tag,
                                    "start", cmd_start[i*CYC_W +: CYC_W], e.st[i]);
                                chk(longint'(cmd_end[i*CYC_W +: CYC_W]) == e.en[i], e.tag,
                                    "end", cmd_end[i*CYC_W +: CYC_W], e.en[i]);
                            end
                        end
                    end
                end
            end
            if (ref_valid) begin
                chk(longint'(ref_start) == plan, "R7", "refresh start", ref_start, plan);
                chk(longint'(ref_end) == plan + T_RFC, "R7", "refresh end", ref_end, plan + T_RFC);
                chk(tb_cyc == plan + 1, "R7", "refresh pulse cycle", tb_cyc, plan + 1);
                for (int b = 0; b < BANKS; b++)
                    if (bk_end[b] < plan + T_RFC) bk_end[b] = plan + T_RFC;
                plan = plan + REF_CYC;
                ref_seen++;
            end
        end
    end

    task automatic wait_until(input longint c);
        while (tb_cyc < c) @(negedge clk);
    endtask

    initial begin
        for (int b = 0; b < BANKS; b++) bk_end[b] = 0;
        repeat (3) @(negedge clk);
        chk(resp_valid == 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
        chk(ref_valid == 1'b0, "R1", "ref_valid in reset", ref_valid, 0);
        chk(cmd_valid == '0, "R1", "cmd_valid in reset", cmd_valid, 0);
        chk(now_cycle == '0, "R1", "now_cycle in reset", now_cycle, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(now_cycle == CYC_W'(1), "R1", "counter after first edge", now_cycle, 1);
        repeat (4) @(negedge clk);
        chk(longint'(now_cycle) == tb_cyc, "R1", "counter tracks clock", now_cycle, tb_cyc);

        // open + read in the future: R2 start, R3 chain, R4 lengths
        issue(0, 2, 0, 2, 0, 8, tb_cyc + 6, "R3");
        // write while bank 0 busy: R5
        issue(0, 1, 3, 0, 0, 4, 0, "R5");
        // close on another bank with a start in the past: R6 and R2
        issue(1, 1, 1, 0, 0, 0, 2, "R6");
        // close, open, write on bank 2: R4 all codes
        issue(2, 3, 1, 0, 3, 7, tb_cyc + 3, "R4");
        // read on bank 2 with start before its end: R2 bank bound
        issue(2, 1, 2, 0, 0, 15, tb_cyc, "R2");
        // empty request is answered and schedules nothing: R10
        issue(3, 0, 0, 0, 0, 0, 0, "R10");

        // refresh window boundaries before the first refresh
        wait_until(3000);
        issue(3, 1, 2, 0, 0, 4, REF_CYC - 9, "R11");         // ends at plan
        issue(4, 1, 2, 0, 0, 4, REF_CYC - 8, "R8");          // ends one past plan
        issue(5, 1, 2, 0, 0, 4, REF_CYC + T_RFC, "R11");     // starts at window end
        issue(6, 2, 0, 2, 0, 4, REF_CYC + T_RFC - 5, "R8");  // first lane inside window
        issue(7, 1, 0, 0, 0, 0, REF_CYC - 2, "R8");          // straddles plan

        // after the refresh: every bank waits for it, later ends kept
        wait_until(REF_CYC + 5);
        issue(4, 1, 1, 0, 0, 0, 0, "R9");   // rejected earlier, now after refresh
        issue(3, 1, 1, 0, 0, 0, 0, "R9");
        issue(7, 1, 0, 0, 0, 0, 0, "R9");
        issue(5, 1, 3, 0, 0, 2, 0, "R9");   // own end beyond the refresh end
        issue(1, 2, 0, 3, 0, 3, 0, "R6");

        wait_until(2 * REF_CYC + 5);
        chk(ref_seen == 2, "R7", "refresh count", ref_seen, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule